// File: doc/BRIEF.md
# Inter-Processor Command and Response Mailbox

This block links a host processor and an embedded service processor through two small register ports. The host sends 16-bit commands by writing them to one command address. Each write lands in a short first-in first-out queue and raises a command-available interrupt toward the service processor. The service processor reads the oldest command at the queue head, and it can see how many entries are waiting. When it has dealt with the head entry it writes zero to a control bit, which drops that entry.

Results travel the other way through one 32-bit response register. This register does not queue. Writing it does not interrupt the host. The service processor raises the host interrupt with a separate explicit write, so it can choose when the host is told. Each side has its own status, acknowledge and mask bits for its interrupt. An interrupt set always wins over an acknowledge that arrives in the same cycle, so no event is lost.

Both ports use single-cycle writes. Read data is combinational from the address. Word addresses: on the host port, 0 is the command register (write), 1 is the response register (read), 2 is the host interrupt status (bit 0, write one to clear) and 3 is the host mask (bit 0). On the service port, 0 is the queue head, 1 is the count register, 2 is the service interrupt status (bit 1), 3 is the service acknowledge register, 4 is the service mask (bit 1), 5 is the control register (bit 0), 6 is the response register (write) and 7 is the host-interrupt-set register (bit 0).

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the queue is empty (count 0, control bit 0 reads 0), both interrupt status bits are 0, both mask bits read 1, and both interrupt outputs are 0.
- R2: Each host write to host address 0 stores its low 16 bits at the queue tail. The queue holds 4 entries. Service address 0 returns the head entry zero-extended. Service address 1 bits [2:0] give the entry count. Entries leave in the order they were written.
- R3: A host command write while 4 entries are held is dropped and sets a sticky overflow flag (service address 1, bit 8). The flag stays set until the service side writes 1 to that bit. A set in the same cycle wins over that clear.
- R4: Every host command write, including a dropped one, sets service status bit 1. Writing 1 to bit 1 of service address 3 clears it. If a command write and that acknowledge fall in the same cycle, the bit ends up set.
- R5: The service interrupt output equals service status bit 1 while service mask bit 1 is 0, and is 0 while that mask bit is 1. The status bit can be read either way.
- R6: Service address 5 bit 0 reads 1 exactly while the queue holds an entry. Writing 0 to that bit drops the head entry. Writing 1 has no effect. A drop on an empty queue has no effect.
- R7: A service write to address 6 stores all 32 bits, which the host reads at host address 1. This write does not change the host interrupt status.
- R8: A service write with bit 0 set to address 7 sets host status bit 0. The host clears it by writing 1 to bit 0 of host address 2. When the set and the clear fall in the same cycle, the bit stays set.
- R9: The host interrupt output equals host status bit 0 while host mask bit 0 is 0, and is 0 while that mask bit is 1. The status bit can still be polled while masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host port access strobe |
| h_we | input | 1 | Host port write enable |
| h_addr | input | 4 | Host port word address |
| h_wdata | input | 16 | Host port write data |
| h_rdata | output | 32 | Host port read data (combinational) |
| s_req | input | 1 | Service port access strobe |
| s_we | input | 1 | Service port write enable |
| s_addr | input | 4 | Service port word address |
| s_wdata | input | 32 | Service port write data |
| s_rdata | output | 32 | Service port read data (combinational) |
| h_irq | output | 1 | Interrupt toward the host |
| s_irq | output | 1 | Interrupt toward the service processor |

## Verification
The queue is tried with single commands, with a full run of four distinct values drained in order, and with a fifth write into a full queue. Together these show whether ordering, the count, the drop rule and the sticky flag are correct. Upper-bit patterns in the command writes and an all-ones response value show whether 16-bit truncation and 32-bit storage are right. Each interrupt path is tried with set alone, acknowledge alone, set and acknowledge in the same cycle, and each mask state. This shows set priority and masking apart from the status bit that stays pollable.

// File: rtl/ipc_mailbox_pkg.sv
// Package: ipc_mailbox_pkg
// Purpose : shared register word addresses for both mailbox ports.
// Assumes : address buses are at least 3 bits wide.
package ipc_mailbox_pkg;

    // host port word addresses
    localparam int unsigned HA_CMD   = 0;
    localparam int unsigned HA_RESP  = 1;
    localparam int unsigned HA_STAT  = 2;
    localparam int unsigned HA_MASK  = 3;

    // service port word addresses
    localparam int unsigned SA_HEAD  = 0;
    localparam int unsigned SA_COUNT = 1;
    localparam int unsigned SA_STAT  = 2;
    localparam int unsigned SA_ACK   = 3;
    localparam int unsigned SA_MASK  = 4;
    localparam int unsigned SA_CTRL  = 5;
    localparam int unsigned SA_RESP  = 6;
    localparam int unsigned SA_HSET  = 7;

    // bit position of the sticky overflow flag in the count register
    localparam int unsigned OVF_BIT  = 8;

endpackage

// File: rtl/ipc_mailbox_cmd_fifo.sv
// Module : ipc_mailbox_cmd_fifo
// Purpose: command queue with entry count and sticky overflow flag.
//          A push into a full queue is dropped unless a pop happens in
//          the same cycle. A pop on an empty queue is ignored.
// Assumes: DEPTH >= 2; synchronous active-low reset.
module ipc_mailbox_cmd_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] cnt,
    output logic             not_empty,
    output logic             ovf
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic             full;
    logic             do_pop;
    logic             do_push;
    logic             drop;

    assign full      = (cnt == CNT_W'(DEPTH));
    assign not_empty = (cnt != '0);
    assign do_pop    = pop && not_empty;
    assign do_push   = push && (!full || do_pop);
    assign drop      = push && !do_push;
    assign head      = mem[rd_ptr];

    // wrap a pointer back to zero after the last slot
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    // storage writes; entries need no reset since count gates their use
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // sticky overflow flag, a drop wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/ipc_mailbox_irq_cell.sv
// Module : ipc_mailbox_irq_cell
// Purpose: one interrupt source with a status bit, an acknowledge and a
//          mask. A set beats an acknowledge in the same cycle. The mask
//          resets to 1 (blocked).
// Assumes: synchronous active-low reset.
module ipc_mailbox_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    input  logic mask_wr,
    input  logic mask_wdata,
    output logic stat,
    output logic mask,
    output logic irq
);

    // status bit, set has priority over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= 1'b0;
        end else if (set) begin
            stat <= 1'b1;
        end else if (ack) begin
            stat <= 1'b0;
        end
    end

    // mask bit, starts blocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= 1'b1;
        end else if (mask_wr) begin
            mask <= mask_wdata;
        end
    end

    assign irq = stat && !mask;

endmodule

// File: rtl/ipc_mailbox.sv
// Module : ipc_mailbox
// Purpose: host to service-processor mailbox. The host pushes 16-bit
//          commands into a queue and each push interrupts the service
//          side. The service side pops through a control bit and returns
//          32-bit results in one register, then raises the host
//          interrupt with a separate write.
// Assumes: single-cycle register writes on both ports; reads are
//          combinational from the address; DATA_W > OVF_BIT and
//          DATA_W >= CMD_W.
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned CMD_W  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [CMD_W-1:0]  h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              s_req,
    input  logic              s_we,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    output logic              h_irq,
    output logic              s_irq
);

    logic              h_wr;
    logic              s_wr;
    logic              push;
    logic              pop;
    logic              ovf_clr;
    logic              s_ack;
    logic              s_mask_wr;
    logic              h_set;
    logic              h_ack;
    logic              h_mask_wr;
    logic              resp_wr;
    logic [CMD_W-1:0]  head;
    logic [CNT_W-1:0]  cnt;
    logic              not_empty;
    logic              ovf;
    logic              s_stat;
    logic              s_mask;
    logic              h_stat;
    logic              h_mask;
    logic [DATA_W-1:0] resp_q;

    // write strobe decode for both ports
    always_comb begin
        h_wr      = h_req && h_we;
        s_wr      = s_req && s_we;
        push      = h_wr && (h_addr == ADDR_W'(HA_CMD));
        h_ack     = h_wr && (h_addr == ADDR_W'(HA_STAT)) && h_wdata[0];
        h_mask_wr = h_wr && (h_addr == ADDR_W'(HA_MASK));
        pop       = s_wr && (s_addr == ADDR_W'(SA_CTRL)) && !s_wdata[0];
        ovf_clr   = s_wr && (s_addr == ADDR_W'(SA_COUNT)) && s_wdata[OVF_BIT];
        s_ack     = s_wr && (s_addr == ADDR_W'(SA_ACK)) && s_wdata[1];
        s_mask_wr = s_wr && (s_addr == ADDR_W'(SA_MASK));
        resp_wr   = s_wr && (s_addr == ADDR_W'(SA_RESP));
        h_set     = s_wr && (s_addr == ADDR_W'(SA_HSET)) && s_wdata[0];
    end

    ipc_mailbox_cmd_fifo #(
        .WIDTH (CMD_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (h_wdata),
        .pop       (pop),
        .ovf_clr   (ovf_clr),
        .head      (head),
        .cnt       (cnt),
        .not_empty (not_empty),
        .ovf       (ovf)
    );

    // service-side command-available interrupt
    ipc_mailbox_irq_cell u_s_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (push),
        .ack        (s_ack),
        .mask_wr    (s_mask_wr),
        .mask_wdata (s_wdata[1]),
        .stat       (s_stat),
        .mask       (s_mask),
        .irq        (s_irq)
    );

    // host-side result-ready interrupt
    ipc_mailbox_irq_cell u_h_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (h_set),
        .ack        (h_ack),
        .mask_wr    (h_mask_wr),
        .mask_wdata (h_wdata[0]),
        .stat       (h_stat),
        .mask       (h_mask),
        .irq        (h_irq)
    );

    // single response register, no queueing, no interrupt side effect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (resp_wr) begin
            resp_q <= s_wdata;
        end
    end

    // host port read mux
    always_comb begin
        h_rdata = '0;
        case (h_addr)
            ADDR_W'(HA_RESP): h_rdata    = resp_q;
            ADDR_W'(HA_STAT): h_rdata[0] = h_stat;
            ADDR_W'(HA_MASK): h_rdata[0] = h_mask;
            default:          h_rdata    = '0;
        endcase
    end

    // service port read mux
    always_comb begin
        s_rdata = '0;
        case (s_addr)
            ADDR_W'(SA_HEAD): s_rdata[CMD_W-1:0] = head;
            ADDR_W'(SA_COUNT): begin
                s_rdata[CNT_W-1:0] = cnt;
                s_rdata[OVF_BIT]   = ovf;
            end
            ADDR_W'(SA_STAT): s_rdata[1] = s_stat;
            ADDR_W'(SA_MASK): s_rdata[1] = s_mask;
            ADDR_W'(SA_CTRL): s_rdata[0] = not_empty;
            default:          s_rdata    = '0;
        endcase
    end

endmodule

// File: rtl/ipc_mailbox_chk.sv
// Module : ipc_mailbox_chk
// Purpose: temporal checks on the mailbox, bound into ipc_mailbox.
// Assumes: same parameters as the bound instance.
module ipc_mailbox_chk
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_req,
    input logic              h_we,
    input logic [ADDR_W-1:0] h_addr,
    input logic              s_req,
    input logic              s_we,
    input logic [ADDR_W-1:0] s_addr,
    input logic [DATA_W-1:0] s_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf,
    input logic              s_stat,
    input logic              s_mask,
    input logic              s_irq,
    input logic              h_stat,
    input logic              h_mask,
    input logic              h_irq
);

    logic c_push;
    logic c_pop;
    logic c_resp;
    logic c_hset;

    // port-level view of the write events
    assign c_push = h_req && h_we && (h_addr == ADDR_W'(HA_CMD));
    assign c_pop  = s_req && s_we && (s_addr == ADDR_W'(SA_CTRL)) && !s_wdata[0];
    assign c_resp = s_req && s_we && (s_addr == ADDR_W'(SA_RESP));
    assign c_hset = s_req && s_we && (s_addr == ADDR_W'(SA_HSET)) && s_wdata[0];

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(DEPTH) && c_push && !c_pop) |=> (cnt == CNT_W'(DEPTH) && ovf));

    p_push_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_push |=> s_stat);

    p_smask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_mask |-> !s_irq);

    p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && c_pop && !c_push) |=> (cnt == '0));

    p_resp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_stat && c_resp) |=> !h_stat);

    p_hset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_hset |=> h_stat);

    p_hmask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        h_mask |-> !h_irq);

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_req   (h_req),
    .h_we    (h_we),
    .h_addr  (h_addr),
    .s_req   (s_req),
    .s_we    (s_we),
    .s_addr  (s_addr),
    .s_wdata (s_wdata),
    .cnt     (cnt),
    .ovf     (ovf),
    .s_stat  (s_stat),
    .s_mask  (s_mask),
    .s_irq   (s_irq),
    .h_stat  (h_stat),
    .h_mask  (h_mask),
    .h_irq   (h_irq)
);

// File: tb/ipc_mailbox_bench.sv
// Bench : ipc_mailbox_bench
// Purpose: directed scenarios, one task each, on the mailbox top.
module ipc_mailbox_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [3:0]  h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        s_req = 1'b0;
    logic        s_we = 1'b0;
    logic [3:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        h_irq;
    logic        s_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipc_mailbox u_ipc_mailbox (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_req   (h_req),
        .h_we    (h_we),
        .h_addr  (h_addr),
        .h_wdata (h_wdata),
        .h_rdata (h_rdata),
        .s_req   (s_req),
        .s_we    (s_we),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_rdata (s_rdata),
        .h_irq   (h_irq),
        .s_irq   (s_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic swrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        s_req = 1'b1; s_we = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0;
    endtask

    // one cycle with a write on each port at the same edge
    task automatic both_write(input logic [3:0] ha, input logic [15:0] hd,
                              input logic [3:0] sa, input logic [31:0] sd);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = ha; h_wdata = hd;
        s_req = 1'b1; s_we = 1'b1; s_addr = sa; s_wdata = sd;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0; s_req = 1'b0; s_we = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic sread(input logic [3:0] a, output logic [31:0] d);
        s_addr = a;
        #1;
        d = s_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        sread(4'd1, d); check("R1", "count after reset", d, 32'h0);
        sread(4'd5, d); check("R1", "control after reset", d, 32'h0);
        sread(4'd2, d); check("R1", "service status", d, 32'h0);
        sread(4'd4, d); check("R1", "service mask", d, 32'h2);
        hread(4'd2, d); check("R1", "host status", d, 32'h0);
        hread(4'd3, d); check("R1", "host mask", d, 32'h1);
        check("R1", "irq outputs", {30'd0, h_irq, s_irq}, 32'h0);
    endtask

    task automatic t_fifo_order();
        logic [31:0] d;
        logic [15:0] vals [4] = '{16'h1234, 16'hFFFF, 16'h0001, 16'hA5C3};
        hwrite(4'd0, vals[0]);
        sread(4'd0, d); check("R2", "head after one push", d, 32'h1234);
        sread(4'd2, d); check("R4", "status set by push", d, 32'h2);
        check("R5", "masked service irq", {31'd0, s_irq}, 32'h0);
        sread(4'd5, d); check("R6", "control shows entry", d, 32'h1);
        for (int i = 1; i < 4; i++) hwrite(4'd0, vals[i]);
        sread(4'd1, d); check("R2", "count full", d, 32'h4);
        for (int i = 0; i < 4; i++) begin
            sread(4'd0, d); check("R2", "order", d, {16'h0, vals[i]});
            swrite(4'd5, 32'h0);
        end
        sread(4'd1, d); check("R2", "count drained", d, 32'h0);
        sread(4'd5, d); check("R6", "control empty", d, 32'h0);
        swrite(4'd3, 32'h2);
        sread(4'd2, d); check("R4", "ack clears status", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) hwrite(4'd0, 16'h0100 + 16'(i));
        hwrite(4'd0, 16'hDEAD);
        sread(4'd1, d); check("R3", "count and overflow", d, 32'h104);
        sread(4'd0, d); check("R3", "head unchanged", d, 32'h0100);
        for (int i = 0; i < 4; i++) begin
            sread(4'd0, d); check("R3", "kept entries", d, 32'h0100 + 32'(i));
            swrite(4'd5, 32'h0);
        end
        sread(4'd1, d); check("R3", "sticky after drain", d, 32'h100);
        swrite(4'd1, 32'h100);
        sread(4'd1, d); check("R3", "overflow cleared", d, 32'h0);
        swrite(4'd3, 32'h2);
    endtask

    task automatic t_pop_rules();
        logic [31:0] d;
        swrite(4'd5, 32'h0);
        sread(4'd1, d); check("R6", "pop on empty", d, 32'h0);
        hwrite(4'd0, 16'h7777);
        swrite(4'd5, 32'h1);
        sread(4'd1, d); check("R6", "write 1 keeps entry", d, 32'h1);
        sread(4'd0, d); check("R6", "head after write 1", d, 32'h7777);
        swrite(4'd5, 32'h0);
        sread(4'd1, d); check("R6", "pop by write 0", d, 32'h0);
        swrite(4'd3, 32'h2);
    endtask

    task automatic t_service_irq();
        logic [31:0] d;
        swrite(4'd4, 32'h0);
        sread(4'd4, d); check("R5", "mask cleared", d, 32'h0);
        hwrite(4'd0, 16'h0042);
        check("R5", "irq unmasked", {31'd0, s_irq}, 32'h1);
        swrite(4'd3, 32'h2);
        check("R4", "irq after ack", {31'd0, s_irq}, 32'h0);
        both_write(4'd0, 16'h0043, 4'd3, 32'h2);
        sread(4'd2, d); check("R4", "set wins over ack", d, 32'h2);
        check("R5", "irq after collision", {31'd0, s_irq}, 32'h1);
        swrite(4'd4, 32'h2);
        check("R5", "irq remasked", {31'd0, s_irq}, 32'h0);
        sread(4'd2, d); check("R5", "status pollable", d, 32'h2);
        swrite(4'd5, 32'h0);
        swrite(4'd5, 32'h0);
        swrite(4'd3, 32'h2);
    endtask

    task automatic t_response();
        logic [31:0] d;
        swrite(4'd6, 32'hFFFF_FFFF);
        hread(4'd1, d); check("R7", "all ones response", d, 32'hFFFF_FFFF);
        swrite(4'd6, 32'hDEAD_BEEF);
        hread(4'd1, d); check("R7", "response value", d, 32'hDEAD_BEEF);
        hread(4'd2, d); check("R7", "no host status", d, 32'h0);
        hwrite(4'd3, 16'h0);
        check("R7", "no host irq", {31'd0, h_irq}, 32'h0);
    endtask

    task automatic t_host_irq();
        logic [31:0] d;
        swrite(4'd7, 32'h1);
        hread(4'd2, d); check("R8", "set host status", d, 32'h1);
        check("R9", "irq unmasked", {31'd0, h_irq}, 32'h1);
        hwrite(4'd2, 16'h1);
        hread(4'd2, d); check("R8", "w1c clears", d, 32'h0);
        both_write(4'd2, 16'h1, 4'd7, 32'h1);
        hread(4'd2, d); check("R8", "set wins over clear", d, 32'h1);
        hwrite(4'd3, 16'h1);
        check("R9", "irq masked", {31'd0, h_irq}, 32'h0);
        hread(4'd2, d); check("R9", "status pollable", d, 32'h1);
        hwrite(4'd2, 16'h0);
        hread(4'd2, d); check("R8", "write 0 keeps", d, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fifo_order();
        t_overflow();
        t_pop_rules();
        t_service_irq();
        t_response();
        t_host_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule